// File: doc/BRIEF.md
# Asymmetric Single-Port Wide Register

This block is one wide register, exactly one scratchpad row wide, made of storage with a single access port. It offers two logical faces. The line face moves a whole row, or a contiguous run of words in a row, between memory and the register in one cycle. The word face gives the datapath one word per access, chosen by a word index. The index drives an output multiplexer for reads and an input demultiplexer for writes, and there is no pre-decode stage.

Both faces share the one physical port, so at most one access is served in any cycle. A line transfer always takes the port. A datapath request made in the same cycle is refused with a stall flag and has no effect. The decoded instruction supplies the request, the direction and the word index.

Reads on either face are combinational from the stored words and return the state held at the start of the cycle. Writes on either face land at the next rising clock edge.

Top module: `wide_reg_file`

## Requirements
- R1: A synchronous active-high reset clears every word to zero.
- R2: A line load (`ln_req`=1, `ln_wr`=1) with `ln_pos`=0 and `ln_cnt`=N_WORDS writes every word from `ln_wdata`. The new values are visible from the next cycle.
- R3: A line load writes only words `ln_pos` through `ln_pos+ln_cnt-1`. The span is clipped at the last word, `ln_cnt`=0 writes nothing, and all words outside the span keep their values.
- R4: A line store (`ln_req`=1, `ln_wr`=0) drives, in the same cycle, the words of the span onto `ln_rdata` and zero elsewhere. It sets `ln_rmask` bit i exactly for each transferred word i and changes no stored word. Without a line store, `ln_rdata` and `ln_rmask` are zero.
- R5: A granted word read (`dp_req`=1, `dp_wr`=0, no line request) returns on `dp_rdata`, in the same cycle, word `dp_idx` as held at the start of that cycle.
- R6: A granted word write (`dp_req`=1, `dp_wr`=1, no line request) updates only word `dp_idx`, visible from the next cycle.
- R7: When `ln_req` and `dp_req` are both high, the line transfer is performed, `dp_stall` is 1, a word write is discarded and `dp_rdata` is zero.
- R8: `dp_stall` is 0 whenever `ln_req` is 0. `dp_rdata` is zero unless a word read is granted.
- R9: Word i occupies bits [i*WORD_W +: WORD_W] of `ln_wdata`, `ln_rdata` and the line layout, and bit i of `ln_rmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_req | input | 1 | Line transfer request |
| ln_wr | input | 1 | 1 = load memory into register, 0 = store register to memory |
| ln_pos | input | IDX_W | First word of the line span |
| ln_cnt | input | CNT_W | Number of words in the span (0..N_WORDS) |
| ln_wdata | input | LINE_W | Line data from memory |
| ln_rdata | output | LINE_W | Line data to memory, span words only |
| ln_rmask | output | N_WORDS | Word valid mask of a line store |
| dp_req | input | 1 | Datapath word access request |
| dp_wr | input | 1 | 1 = word write, 0 = word read |
| dp_idx | input | IDX_W | Word index |
| dp_wdata | input | WORD_W | Word write data |
| dp_rdata | output | WORD_W | Word read data |
| dp_stall | output | 1 | Datapath request refused this cycle |

## Verification
The read results `ln_rdata`, `ln_rmask`, `dp_rdata` and the `dp_stall` flag are due in the same cycle as the request, with no register in the path. Write effects of loads and word writes are due one clock edge later. The bench applies each request at the falling edge and compares all four outputs 1 ns later against a behavioural model. That model holds the pre-edge state, so same-cycle reads see old data. It then commits the model's writes at the rising edge, so any write shows up in the next cycle's comparisons and read-backs.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_LINE_LOAD,
        ACC_LINE_STORE,
        ACC_WORD_RD,
        ACC_WORD_WR
    } acc_e;

    // word i lies inside a span that starts at pos and holds cnt words
    function automatic logic in_span(input int unsigned i, input int unsigned pos,
                                     input int unsigned cnt);
        return (i >= pos) && (i < pos + cnt);
    endfunction

endpackage

// File: rtl/wreg_arb.sv
module wreg_arb
    import wreg_pkg::*;
(
    input  logic ln_req,
    input  logic ln_wr,
    input  logic dp_req,
    input  logic dp_wr,
    output acc_e kind,
    output logic dp_stall
);
    always_comb begin
        if (ln_req)      kind = ln_wr ? ACC_LINE_LOAD : ACC_LINE_STORE;
        else if (dp_req) kind = dp_wr ? ACC_WORD_WR : ACC_WORD_RD;
        else             kind = ACC_IDLE;
    end

    assign dp_stall = dp_req && ln_req;
endmodule

// File: rtl/wreg_span.sv
module wreg_span
    import wreg_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int IDX_W   = $clog2(N_WORDS),
    parameter int CNT_W   = $clog2(N_WORDS + 1)
) (
    input  logic [IDX_W-1:0]   pos,
    input  logic [CNT_W-1:0]   cnt,
    output logic [N_WORDS-1:0] mask
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        assign mask[i] = in_span(i, int'(pos), int'(cnt));
    end
endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int LINE_W  = WORD_W * N_WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_WORDS-1:0] we,
    input  logic [LINE_W-1:0]  din,
    output logic [LINE_W-1:0]  q
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)        q[i*WORD_W +: WORD_W] <= '0;
            else if (we[i]) q[i*WORD_W +: WORD_W] <= din[i*WORD_W +: WORD_W];
        end

        // R3 / R6: a word without write enable holds its value
        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> q[i*WORD_W +: WORD_W] == $past(q[i*WORD_W +: WORD_W]));

        // R6 / R2: an enabled write is visible in the next cycle
        p_visible_r6: assert property (@(posedge clk) disable iff (rst)
            we[i] |=> q[i*WORD_W +: WORD_W] == $past(din[i*WORD_W +: WORD_W]));
    end
endmodule

// File: rtl/wide_reg_file.sv
module wide_reg_file
    import wreg_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    localparam int IDX_W  = $clog2(N_WORDS),
    localparam int CNT_W  = $clog2(N_WORDS + 1),
    localparam int LINE_W = WORD_W * N_WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ln_req,
    input  logic               ln_wr,
    input  logic [IDX_W-1:0]   ln_pos,
    input  logic [CNT_W-1:0]   ln_cnt,
    input  logic [LINE_W-1:0]  ln_wdata,
    output logic [LINE_W-1:0]  ln_rdata,
    output logic [N_WORDS-1:0] ln_rmask,
    input  logic               dp_req,
    input  logic               dp_wr,
    input  logic [IDX_W-1:0]   dp_idx,
    input  logic [WORD_W-1:0]  dp_wdata,
    output logic [WORD_W-1:0]  dp_rdata,
    output logic               dp_stall
);
    acc_e               kind;
    logic [N_WORDS-1:0] span;
    logic [N_WORDS-1:0] word_we;
    logic [LINE_W-1:0]  word_din;
    logic [LINE_W-1:0]  q;
    logic               is_load, is_store, is_wr, is_rd;

    wreg_arb u_arb (
        .ln_req   (ln_req),
        .ln_wr    (ln_wr),
        .dp_req   (dp_req),
        .dp_wr    (dp_wr),
        .kind     (kind),
        .dp_stall (dp_stall)
    );

    wreg_span #(.N_WORDS(N_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_span (
        .pos  (ln_pos),
        .cnt  (ln_cnt),
        .mask (span)
    );

    assign is_load  = (kind == ACC_LINE_LOAD);
    assign is_store = (kind == ACC_LINE_STORE);
    assign is_wr    = (kind == ACC_WORD_WR);
    assign is_rd    = (kind == ACC_WORD_RD);

    // write demux and line-side mask, one slice per word
    for (genvar i = 0; i < N_WORDS; i++) begin : g_slice
        assign word_we[i] = (is_load && span[i]) || (is_wr && dp_idx == IDX_W'(i));
        assign word_din[i*WORD_W +: WORD_W] =
            is_load ? ln_wdata[i*WORD_W +: WORD_W] : dp_wdata;
        assign ln_rmask[i] = is_store && span[i];
        assign ln_rdata[i*WORD_W +: WORD_W] =
            ln_rmask[i] ? q[i*WORD_W +: WORD_W] : '0;
    end

    wreg_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .LINE_W(LINE_W)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (word_we),
        .din (word_din),
        .q   (q)
    );

    // read mux
    always_comb begin
        dp_rdata = '0;
        for (int i = 0; i < N_WORDS; i++)
            if (is_rd && dp_idx == IDX_W'(i)) dp_rdata = q[i*WORD_W +: WORD_W];
    end

    // R6: a granted word write touches exactly one word
    p_one_word_r6: assert property (@(posedge clk) disable iff (rst)
        (dp_req && dp_wr && !ln_req) |-> $countones(word_we) == 1);

    // R4: a line store never writes the storage
    p_store_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (ln_req && !ln_wr) |-> word_we == '0);

    // R7: a stalled request gets no read data and no word write
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        dp_stall |-> (dp_rdata == '0) && (kind != ACC_WORD_WR) && (kind != ACC_WORD_RD));

    // R8: no stall without a line request
    p_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !ln_req |-> !dp_stall);

    // R4: store mask only during line store
    p_mask_r4: assert property (@(posedge clk) disable iff (rst)
        !(ln_req && !ln_wr) |-> ln_rmask == '0);
endmodule

// File: tb/wide_reg_file_tb_top.sv
`timescale 1ns/1ps
module wide_reg_file_tb_top;
    localparam int W = 32;
    localparam int N = 8;
    localparam int L = W * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ln_req = 0, ln_wr = 0;
    logic [2:0]   ln_pos = '0;
    logic [3:0]   ln_cnt = '0;
    logic [L-1:0] ln_wdata = '0;
    logic [L-1:0] ln_rdata;
    logic [N-1:0] ln_rmask;
    logic         dp_req = 0, dp_wr = 0;
    logic [2:0]   dp_idx = '0;
    logic [W-1:0] dp_wdata = '0;
    logic [W-1:0] dp_rdata;
    logic         dp_stall;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model [N];

    always #2 clk = ~clk;   // 250 MHz

    wide_reg_file #(.WORD_W(W), .N_WORDS(N)) dut_i (
        .clk(clk), .rst(rst),
        .ln_req(ln_req), .ln_wr(ln_wr), .ln_pos(ln_pos), .ln_cnt(ln_cnt),
        .ln_wdata(ln_wdata), .ln_rdata(ln_rdata), .ln_rmask(ln_rmask),
        .dp_req(dp_req), .dp_wr(dp_wr), .dp_idx(dp_idx), .dp_wdata(dp_wdata),
        .dp_rdata(dp_rdata), .dp_stall(dp_stall)
    );

    task automatic chk(input string tag, input string what,
                       input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [L-1:0] pat(input int seed);
        logic [L-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = 32'h9E37_0000 * seed + 32'h0101 * i + seed;
        return v;
    endfunction

    // one clock cycle: drive at falling edge, compare 1 ns later, commit model at rising edge
    task automatic cyc(input string tag, input bit lr, input bit lw, input int pos,
                       input int cnt, input logic [L-1:0] lwd, input bit dr, input bit dw,
                       input int idx, input logic [W-1:0] dwd);
        logic [L-1:0] e_rd;
        logic [N-1:0] e_mask;
        logic [W-1:0] e_dp;
        @(negedge clk);
        ln_req = lr; ln_wr = lw; ln_pos = 3'(pos); ln_cnt = 4'(cnt); ln_wdata = lwd;
        dp_req = dr; dp_wr = dw; dp_idx = 3'(idx); dp_wdata = dwd;
        #1;
        e_rd = '0; e_mask = '0;
        for (int i = 0; i < N; i++)
            if (lr && !lw && i >= pos && i < pos + cnt) begin
                e_mask[i] = 1'b1;
                e_rd[i*W +: W] = model[i];
            end
        e_dp = (dr && !dw && !lr) ? model[idx] : '0;
        chk((lr && !lw) ? "R4" : "R4/R8", "ln_rdata", ln_rdata, e_rd);
        chk("R4/R9", "ln_rmask", L'(ln_rmask), L'(e_mask));
        chk(tag, "dp_rdata", L'(dp_rdata), L'(e_dp));
        chk((lr && dr) ? "R7" : "R8", "dp_stall", L'(dp_stall), L'(lr && dr));
        @(posedge clk);
        if (lr && lw) begin
            for (int i = 0; i < N; i++)
                if (i >= pos && i < pos + cnt) model[i] = lwd[i*W +: W];
        end else if (dr && dw && !lr) begin
            model[idx] = dwd;
        end
    endtask

    task automatic rd(input string tag, input int idx);
        cyc(tag, 0, 0, 0, 0, '0, 1, 0, idx, '0);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < N; i++) rd(tag, i);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        // reset with a load request present: reset must win (R1)
        ln_req = 1; ln_wr = 1; ln_pos = 0; ln_cnt = 8; ln_wdata = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; ln_req = 0;
        // R1: all words zero after reset
        read_all("R1");

        // R2: full line load, then R9 placement via word reads
        cyc("R2", 1, 1, 0, 8, pat(1), 0, 0, 0, '0);
        read_all("R2/R9");
        chk("R9", "word5 slice", L'(model[5]), L'(pat(1)[5*W +: W]));

        // R3: partial load inside the line
        cyc("R3", 1, 1, 2, 3, pat(2), 0, 0, 0, '0);
        read_all("R3");
        // R3: span clipped at the last word
        cyc("R3", 1, 1, 6, 5, pat(3), 0, 0, 0, '0);
        read_all("R3");
        // R3: zero count writes nothing
        cyc("R3", 1, 1, 4, 0, pat(4), 0, 0, 0, '0);
        read_all("R3");

        // R4: full and partial stores, state unchanged afterwards
        cyc("R4", 1, 0, 0, 8, '0, 0, 0, 0, '0);
        cyc("R4", 1, 0, 1, 4, '0, 0, 0, 0, '0);
        cyc("R4", 1, 0, 7, 3, '0, 0, 0, 0, '0);
        read_all("R4");

        // R6: word writes at both ends, only that word changes
        cyc("R6", 0, 0, 0, 0, '0, 1, 1, 0, 32'hDEAD_0000);
        cyc("R6", 0, 0, 0, 0, '0, 1, 1, 7, 32'hBEEF_0007);
        read_all("R6");
        // R5: read right after write sees new value; write cycle itself returns zero
        cyc("R5", 0, 0, 0, 0, '0, 1, 1, 3, 32'h1234_5678);
        rd("R5", 3);

        // R7: line load vs word write, line store vs word read
        cyc("R7", 1, 1, 0, 2, pat(5), 1, 1, 4, 32'hFFFF_FFFF);
        cyc("R7", 1, 0, 0, 8, '0, 1, 0, 4, '0);
        read_all("R7");

        // R5/R8: mixed traffic
        for (int k = 0; k < 400; k++)
            cyc("R5", $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 7), $urandom_range(0, 8),
                {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 7), $urandom);
        read_all("R5");

        finish_run();
    end
endmodule